// File: doc/BRIEF.md
# Triggered Single-Write AXI4-Lite Master

This block is a write-only AXI4-Lite master. It has the address-write, write-data and write-response channels and no read channels. A one-cycle pulse on its trigger input, seen while the block is idle, starts exactly one write. The target address and the write data come from two wide inputs. The block samples both inputs in the same cycle that it accepts the trigger.

After the trigger, the block raises the address and data VALIDs together. It holds each VALID until that channel's own READY arrives, and the two channels may finish in either order. Once both have finished, the block raises BREADY. It waits for the response and then returns to idle, whatever response code the slave returns.

While a transaction is in flight, the block ignores any further trigger. It goes on ignoring them up to and including the cycle of the response handshake. A typical use is to let a small control register fire one posted write toward memory.

Top module: `trig_axil_wr_master`

## Requirements
- R1: A trigger pulse sampled in idle starts one write: awvalid_o and wvalid_o both go high on the clock edge that samples the trigger, so they are visible in the next cycle.
- R2: awaddr_o carries the value of addr_i sampled at trigger acceptance and stays stable while awvalid_o is high, even if addr_i changes.
- R3: wdata_o carries the value of data_i sampled at trigger acceptance and stays stable while wvalid_o is high, even if data_i changes.
- R4: Each of awvalid_o and wvalid_o stays high until its own ready is sampled high, and goes low in the cycle after that handshake. The two handshakes may complete in either order and after any number of wait cycles.
- R5: While the write is offered, wstrb_o is all ones and awprot_o is 3'b000.
- R6: Every trigger pulse from acceptance up to and including the B handshake cycle is ignored, so no second write is issued.
- R7: bready_o rises in the cycle after the later of the two handshakes, stays high until bvalid_i is sampled, and the block then returns to idle with bready_o low, whatever the value of bresp_i.
- R8: While rst_ni is low, awvalid_o, wvalid_o and bready_o are low, and the block comes out of reset idle, abandoning any transaction that was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | One-cycle write request pulse |
| addr_i | input | ADDR_W | Target address, sampled on trigger acceptance |
| data_i | input | DATA_W | Write data, sampled on trigger acceptance |
| awaddr_o | output | ADDR_W | Write address channel address |
| awprot_o | output | 3 | Write address protection, tied to zero |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| wdata_o | output | DATA_W | Write data |
| wstrb_o | output | DATA_W/8 | Write strobes, all ones |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| bresp_i | input | 2 | Write response code (not inspected) |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |

## Verification
The bench varies the READY delays on the two channels so that the address channel finishes first in some writes, the data channel first in others, and both together in the rest. A design that waited for both READYs at once, or that dropped a VALID early, would lose a handshake or offer a channel twice. It changes addr_i and data_i right after each trigger, which exposes a design that passes the inputs straight through instead of sampling them. It pulses the trigger at random while a write is outstanding and then watches the idle cycles for a second, unwanted write. It also checks the exact cycle in which bready_o rises, uses error response codes, and pulls reset in the middle of a write.

// File: rtl/axil_wr_pkg.sv
package axil_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } wr_state_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_AW  = 0;
  localparam int unsigned CH_W   = 1;
endpackage

// File: rtl/axil_wr_capture.sv
module axil_wr_capture #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/axil_chan_slot.sv
module axil_chan_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  output logic valid_o,
  output logic done_o
);
  logic hs;
  assign hs = valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (start_i) begin
      valid_o <= 1'b1;
      done_o  <= 1'b0;
    end else if (hs) begin
      valid_o <= 1'b0;
      done_o  <= 1'b1;
    end
  end

  a_r4_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o);
  a_r4_valid_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i |=> !valid_o);
endmodule

// File: rtl/axil_wr_seq.sv
module axil_wr_seq
  import axil_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [NUM_CH-1:0] valid_i,
  input  logic [NUM_CH-1:0] ready_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic              bvalid_i,
  output logic              start_o,
  output logic              bready_o
);
  wr_state_e state_q, state_d;
  logic [NUM_CH-1:0] fin;
  logic all_fin;

  // a channel counts as finished if done earlier or handshaking now
  for (genvar i = 0; i < NUM_CH; i++) begin : g_fin
    assign fin[i] = done_i[i] | (valid_i[i] & ready_i[i]);
  end
  assign all_fin = &fin;

  assign start_o  = (state_q == ST_IDLE) && trig_i;
  assign bready_o = (state_q == ST_RESP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (trig_i)   state_d = ST_XFER;
      ST_XFER: if (all_fin)  state_d = ST_RESP;
      ST_RESP: if (bvalid_i) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !start_o);
  a_r7_bready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bready_o |-> (valid_i == '0));
endmodule

// File: rtl/trig_axil_wr_master.sv
module trig_axil_wr_master
  import axil_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  trig_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [ADDR_W-1:0]     awaddr_o,
  output logic [2:0]            awprot_o,
  output logic                  awvalid_o,
  input  logic                  awready_i,
  output logic [DATA_W-1:0]     wdata_o,
  output logic [DATA_W/8-1:0]   wstrb_o,
  output logic                  wvalid_o,
  input  logic                  wready_i,
  input  logic [1:0]            bresp_i,
  input  logic                  bvalid_i,
  output logic                  bready_o
);
  localparam int unsigned STRB_W = DATA_W / 8;

  logic              start;
  logic [NUM_CH-1:0] ch_valid, ch_ready, ch_done;
  logic              bresp_unused;

  assign ch_ready[CH_AW] = awready_i;
  assign ch_ready[CH_W]  = wready_i;
  assign bresp_unused    = ^bresp_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    axil_chan_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .ready_i (ch_ready[i]),
      .valid_o (ch_valid[i]),
      .done_o  (ch_done[i])
    );
  end

  axil_wr_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig_i),
    .valid_i  (ch_valid),
    .ready_i  (ch_ready),
    .done_i   (ch_done),
    .bvalid_i (bvalid_i),
    .start_o  (start),
    .bready_o (bready_o)
  );

  axil_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .addr_i (addr_i),
    .data_i (data_i),
    .addr_o (awaddr_o),
    .data_o (wdata_o)
  );

  assign awvalid_o = ch_valid[CH_AW];
  assign wvalid_o  = ch_valid[CH_W];
  assign awprot_o  = 3'b000;
  assign wstrb_o   = {STRB_W{1'b1}};

  a_r1_pair_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awvalid_o) |-> $rose(wvalid_o));
  a_r2_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_o && !awready_i |=> $stable(awaddr_o));
  a_r3_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o && !wready_i |=> $stable(wdata_o));
  a_r7_bready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bready_o && !bvalid_i |=> bready_o);
  a_r8_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !awvalid_o && !wvalid_o && !bready_o);
endmodule

// File: tb/trig_axil_wr_master_tb.sv
module trig_axil_wr_master_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;
  logic [ADDR_W-1:0] awaddr;
  logic [2:0] awprot;
  logic awvalid, wvalid, bready;
  logic awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W/8-1:0] wstrb;
  logic [1:0] bresp = 2'b00;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  trig_axil_wr_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .addr_i(addr), .data_i(data),
    .awaddr_o(awaddr), .awprot_o(awprot), .awvalid_o(awvalid), .awready_i(awready),
    .wdata_o(wdata), .wstrb_o(wstrb), .wvalid_o(wvalid), .wready_i(wready),
    .bresp_i(bresp), .bvalid_i(bvalid), .bready_o(bready)
  );

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_txn(input logic [31:0] a, input logic [31:0] d, input int awd,
                         input int wd, input int bd, input logic [1:0] rsp, input bit noise);
    int awc = 0, wc = 0, bc = 0, k = 0, awk = -1, wk = -1;
    bit awh = 0, wh = 0, bh = 0, bseen = 0;
    logic [31:0] ga = '0, gd = '0;
    @(negedge clk);
    trig = 1'b1; addr = a; data = d;
    @(negedge clk);
    trig = 1'b0; addr = $urandom; data = $urandom;
    chk(awvalid && wvalid, "R1", {awvalid, wvalid}, 2'b11);
    chk(!bready, "R7", bready, 0);
    while (!bh && k < 80) begin
      if (awh) begin
        awready = 1'b0;
        if (k == awk + 1) chk(!awvalid, "R4", awvalid, 0);
      end else begin
        chk(awvalid, "R4", awvalid, 1);
        if (awc >= awd) begin
          awready = 1'b1; ga = awaddr; awh = 1; awk = k;
          chk(awprot == 3'b000 && wstrb == '1, "R5", {awprot, wstrb}, {3'b000, 4'hf});
        end else begin
          awready = 1'b0; awc++;
        end
      end
      if (wh) begin
        wready = 1'b0;
        if (k == wk + 1) chk(!wvalid, "R4", wvalid, 0);
      end else begin
        chk(wvalid, "R4", wvalid, 1);
        if (wc >= wd) begin
          wready = 1'b1; gd = wdata; wh = 1; wk = k;
        end else begin
          wready = 1'b0; wc++;
        end
      end
      if (bready) begin
        if (!bseen) begin
          bseen = 1;
          chk(awh && wh && k == max2(awk, wk) + 1, "R7", k, max2(awk, wk) + 1);
        end
        if (bc >= bd) begin
          bvalid = 1'b1; bresp = rsp; bh = 1;
        end else begin
          bvalid = 1'b0; bc++;
        end
      end else begin
        chk(!(awh && wh && k > max2(awk, wk) + 1), "R7", bready, 1);
      end
      trig = noise ? 1'($urandom % 2) : 1'b0;
      @(negedge clk);
      k++;
    end
    bvalid = 1'b0; awready = 1'b0; wready = 1'b0; trig = 1'b0;
    chk(bh, "R7", bh, 1);
    chk(!bready && !awvalid && !wvalid, "R7", {bready, awvalid, wvalid}, 0);
    chk(ga == a, "R2", ga, a);
    chk(gd == d, "R3", gd, d);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!awvalid && !wvalid, "R6", {awvalid, wvalid}, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    @(negedge clk);
    chk(!awvalid && !wvalid && !bready, "R8", {awvalid, wvalid, bready}, 0);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(!awvalid && !wvalid, "R8", {awvalid, wvalid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!awvalid && !wvalid && !bready, "R8", {awvalid, wvalid, bready}, 0);

    run_txn(32'h0000_1000, 32'hdead_beef, 0, 0, 0, 2'b00, 0);
    run_txn(32'h0000_2004, 32'h1234_5678, 0, 3, 1, 2'b00, 1); // AW first
    run_txn(32'h0000_3008, 32'hcafe_f00d, 4, 0, 2, 2'b10, 1); // W first, SLVERR
    run_txn(32'hffff_fffc, 32'h0000_0000, 2, 2, 0, 2'b11, 1); // together, DECERR
    run_txn(32'h0000_0000, 32'hffff_ffff, 0, 0, 5, 2'b01, 1);

    // reset during a write
    @(negedge clk);
    trig = 1'b1; addr = 32'h40; data = 32'h55;
    @(negedge clk);
    trig = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!awvalid && !wvalid && !bready, "R8", {awvalid, wvalid, bready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!awvalid && !wvalid && !bready, "R8", {awvalid, wvalid, bready}, 0);
    run_txn(32'h0000_0044, 32'h0bad_cafe, 1, 0, 0, 2'b00, 0);

    for (int n = 0; n < 40; n++) begin
      run_txn($urandom, $urandom, $urandom % 5, $urandom % 5, $urandom % 4,
              2'($urandom % 4), 1'($urandom % 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule